// File: doc/BRIEF.md
# Timer Channel with Sticky Compare/Capture Status Flags

A single up/down timer channel with two general registers, A and B, and one byte of sticky event flags. A direction input selects whether the counter counts up or down. Each general register has its own mode input. In compare mode it raises its flag when the running counter equals it. In capture mode a capture pulse copies the counter into the register and raises the flag on the same edge.

A third flag records a counter wrap in either direction. A flag can only be cleared by a two-step handshake. Software first reads the status word while the flag is 1, which arms the flag. A following write of 0 to that bit then clears it. Any status write disarms every flag, and a set event in the clearing cycle keeps the flag at 1.

A synchronous register bus with a combinational read path gives access to the status word, the counter and both general registers. The register addresses are: 0 status, 1 counter, 2 register A, 3 register B.

Top module: `tcc_channel`

## Requirements
- R1: After reset all three flags and all arm bits are 0, the counter is 0, and both general registers hold all ones.
- R2: A status read returns flag A in bit 0, flag B in bit 1 and the wrap flag in bit 2. Bits 6..3 read as 1, bit 7 has no defined value, and bits above 7 read as 0.
- R3: When counting up, a step from all ones to 0 sets the wrap flag on the same edge on which the counter becomes 0.
- R4: When counting down, a step from 0 to all ones sets the wrap flag.
- R5: A general register in compare mode (mode input 0) sets its flag on an edge where counting is enabled and the counter's current value equals the register.
- R6: A general register in capture mode (mode input 1) that sees a capture pulse loads the counter's current value and sets its flag on the same edge.
- R7: A status write of 0 to a flag that has not been armed by a status read showing it as 1 leaves the flag at 1.
- R8: A status read showing a flag as 1, followed by a status write of 0 to that bit, clears the flag. Writing 1 to a flag bit has no effect. Every status write disarms all flags.
- R9: If a set event and a valid clear fall on the same edge, the flag stays 1.
- R10: Writes to status bits 7..3 are ignored. A capture pulse takes priority over a bus write to the same general register.
- R11: A bus write to the counter loads it and takes priority over counting. Such a loaded cycle produces no wrap event. Otherwise the counter moves by one on each enabled cycle, in the selected direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable |
| cnt_down | input | 1 | 1 counts down, 0 counts up |
| mode_cap_a | input | 1 | Register A mode, 1 capture, 0 compare |
| mode_cap_b | input | 1 | Register B mode, 1 capture, 0 compare |
| cap_pulse_a | input | 1 | Capture pulse for register A |
| cap_pulse_b | input | 1 | Capture pulse for register B |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational from the address |

## Verification
The assertions assume that each bus access is a single-cycle strobe and that a read and a write never occur in the same cycle. They also assume that a status read arms a flag only for the next status write. The bench holds every strobe for exactly one clock and drives all inputs at the falling edge. It keeps counting disabled during register accesses, except in the cycles that deliberately overlap a bus write with a count or a capture. In compare tests the bench stops the counter before it clears a flag, so that a standing match cannot set the flag again.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int ADDR_W    = 2;
  localparam int NUM_FLAGS = 3;
  localparam int FLAG_A    = 0;
  localparam int FLAG_B    = 1;
  localparam int FLAG_WRAP = 2;
  localparam int MAX_W     = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT  = 2'd0,
    REG_COUNT = 2'd1,
    REG_GEN_A = 2'd2,
    REG_GEN_B = 2'd3
  } reg_sel_e;

  function automatic logic [MAX_W-1:0] width_mask(input int w);
    return (w >= MAX_W) ? {MAX_W{1'b1}} : ((MAX_W'(1) << w) - MAX_W'(1));
  endfunction

  // Next counter value after one step in the chosen direction.
  function automatic logic [MAX_W-1:0] step_count(input logic [MAX_W-1:0] val,
                                                  input logic down, input int w);
    return (down ? (val - MAX_W'(1)) : (val + MAX_W'(1))) & width_mask(w);
  endfunction

  // True when the next step crosses the end of the range.
  function automatic logic step_wraps(input logic [MAX_W-1:0] val,
                                      input logic down, input int w);
    return down ? (val == '0) : (val == width_mask(w));
  endfunction
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             down,
  output logic [CNT_W-1:0] count_q,
  output logic             wrap_evt
);
  import tcc_pkg::*;

  logic [CNT_W-1:0] count_d;

  assign wrap_evt = en && !load && step_wraps(MAX_W'(count_q), down, CNT_W);

  always_comb begin
    if (load)    count_d = load_val;
    else if (en) count_d = CNT_W'(step_count(MAX_W'(count_q), down, CNT_W));
    else         count_d = count_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end
endmodule

// File: rtl/tcc_gen_reg.sv
module tcc_gen_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic             cap_pulse,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] count_q,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] gen_q,
  output logic             hit_evt
);
  logic capture, compare;

  assign capture = cap_mode && cap_pulse;
  assign compare = !cap_mode && cnt_en && (count_q == gen_q);
  assign hit_evt = capture || compare;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gen_q <= '1;
    else if (capture) gen_q <= count_q;
    else if (wr)      gen_q <= wdata;
  end
endmodule

// File: rtl/tcc_status.sv
module tcc_status #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_evt,
  input  logic             rd,
  input  logic             wr,
  input  logic [NFLAG-1:0] wdata,
  output logic [NFLAG-1:0] flag_q,
  output logic [NFLAG-1:0] arm_q
);
  logic [NFLAG-1:0] clr, flag_d, arm_d;

  assign clr    = {NFLAG{wr}} & arm_q & ~wdata;
  assign flag_d = set_evt | (flag_q & ~clr);

  always_comb begin
    if (wr)      arm_d = '0;
    else if (rd) arm_d = arm_q | flag_q;
    else         arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      arm_q  <= '0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel #(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cnt_en,
  input  logic                      cnt_down,
  input  logic                      mode_cap_a,
  input  logic                      mode_cap_b,
  input  logic                      cap_pulse_a,
  input  logic                      cap_pulse_b,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [tcc_pkg::ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]          bus_wdata,
  output logic [CNT_W-1:0]          bus_rdata
);
  import tcc_pkg::*;

  localparam int NGEN = 2;
  localparam logic [3:0] RSVD_ONES = 4'hF;

  logic                 stat_rd, stat_wr, cnt_wr;
  logic                 wrap_evt;
  logic [CNT_W-1:0]     count_q;
  logic [NUM_FLAGS-1:0] flag_q, arm_q, set_evt;
  logic [NGEN-1:0]      hit_evt, gen_wr, mode_v, pulse_v;
  logic [CNT_W-1:0]     gen_q [NGEN];
  logic [CNT_W-1:0]     gen_a_q, gen_b_q;
  logic [7:0]           stat_byte;

  assign stat_rd = bus_sel && !bus_wr && (bus_addr == REG_STAT);
  assign stat_wr = bus_sel &&  bus_wr && (bus_addr == REG_STAT);
  assign cnt_wr  = bus_sel &&  bus_wr && (bus_addr == REG_COUNT);
  assign mode_v  = {mode_cap_b, mode_cap_a};
  assign pulse_v = {cap_pulse_b, cap_pulse_a};

  tcc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_wr), .load_val(bus_wdata),
    .en(cnt_en), .down(cnt_down), .count_q(count_q), .wrap_evt(wrap_evt)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    assign gen_wr[g] = bus_sel && bus_wr &&
                       (bus_addr == ADDR_W'(int'(REG_GEN_A) + g));
    tcc_gen_reg #(.CNT_W(CNT_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .cap_mode(mode_v[g]), .cap_pulse(pulse_v[g]),
      .cnt_en(cnt_en), .count_q(count_q), .wr(gen_wr[g]), .wdata(bus_wdata),
      .gen_q(gen_q[g]), .hit_evt(hit_evt[g])
    );
  end

  assign gen_a_q = gen_q[0];
  assign gen_b_q = gen_q[1];

  assign set_evt[FLAG_A]    = hit_evt[0];
  assign set_evt[FLAG_B]    = hit_evt[1];
  assign set_evt[FLAG_WRAP] = wrap_evt;

  tcc_status #(.NFLAG(NUM_FLAGS)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .rd(stat_rd), .wr(stat_wr),
    .wdata(bus_wdata[NUM_FLAGS-1:0]), .flag_q(flag_q), .arm_q(arm_q)
  );

  assign stat_byte = {1'b0, RSVD_ONES, flag_q};

  always_comb begin
    unique case (bus_addr)
      REG_STAT:  bus_rdata = CNT_W'(stat_byte);
      REG_COUNT: bus_rdata = count_q;
      REG_GEN_A: bus_rdata = gen_a_q;
      default:   bus_rdata = gen_b_q;
    endcase
  end
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       flags,
  input logic [2:0]       arm,
  input logic             wrap_evt,
  input logic [1:0]       hit_evt,
  input logic             stat_rd,
  input logic             stat_wr,
  input logic             cap_mode_b,
  input logic             cap_pulse_b,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] gen_b,
  input logic [CNT_W-1:0] rdata
);
  p_wrap_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flags[2]);
  p_hit_a_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt[0] |=> flags[0]);
  p_hit_b_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt[1] |=> flags[1]);
  p_capture_copies_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_mode_b && cap_pulse_b) |=> (gen_b == $past(count_q)));
  p_unarmed_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !arm[0]) |=> flags[0]);
  p_no_write_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[1] && !stat_wr) |=> flags[1]);
  p_write_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (arm == 3'b000));
  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt[0] && stat_wr) |=> flags[0]);
  p_rsvd_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (rdata[6:3] == 4'hF));
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flag_q), .arm(arm_q), .wrap_evt(wrap_evt),
  .hit_evt(hit_evt), .stat_rd(stat_rd), .stat_wr(stat_wr),
  .cap_mode_b(mode_cap_b), .cap_pulse_b(cap_pulse_b), .count_q(count_q),
  .gen_b(gen_b_q), .rdata(bus_rdata)
);

// File: tb/tcc_channel_test.sv
module tcc_channel_test;
  localparam int W = 16;
  localparam logic [1:0] A_STAT = 2'd0, A_CNT = 2'd1, A_GA = 2'd2, A_GB = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, cnt_down = 0, mode_cap_a = 0, mode_cap_b = 0;
  logic cap_pulse_a = 0, cap_pulse_b = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0, bus_rdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tcc_channel #(.CNT_W(W)) uut (.*);

  // Vector: start, down, steps, expected count, expected wrap flag.
  localparam int NV = 6;
  localparam logic [41:0] VEC [NV] = '{
    {16'hFFFE, 1'b0, 8'd3, 16'h0001, 1'b1},
    {16'h0010, 1'b0, 8'd5, 16'h0015, 1'b0},
    {16'h0001, 1'b1, 8'd2, 16'hFFFF, 1'b1},
    {16'h8000, 1'b1, 8'd1, 16'h7FFF, 1'b0},
    {16'hFFFF, 1'b0, 8'd1, 16'h0000, 1'b1},
    {16'h0000, 1'b1, 8'd1, 16'hFFFF, 1'b1}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic run(input int n);
    @(negedge clk); cnt_en = 1;
    repeat (n) @(negedge clk);
    cnt_en = 0;
  endtask

  // Status with bit 7 masked off (its value is not defined).
  task automatic rd_stat(output logic [W-1:0] d);
    logic [W-1:0] t;
    rd(A_STAT, t);
    d = t & 16'hFF7F;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R2: reset state
    rd_stat(v);   check("R1 R2 status after reset", v, 16'h0078);
    rd(A_CNT, v); check("R1 counter after reset", v, 16'h0000);
    rd(A_GA, v);  check("R1 reg A after reset", v, 16'hFFFF);
    rd(A_GB, v);  check("R1 reg B after reset", v, 16'hFFFF);

    // R3 R4 R11: vector table, both registers in capture mode with no pulses
    mode_cap_a = 1; mode_cap_b = 1;
    for (int i = 0; i < NV; i++) begin
      logic [41:0] e;
      e = VEC[i];
      wr(A_CNT, e[41:26]);
      cnt_down = e[25];
      run(int'(e[24:17]));
      rd(A_CNT, v);  check("R11 counter after steps", v, e[16:1]);
      rd_stat(v);    check("R3 R4 wrap flag", v, {13'h0, e[0], 2'b00} | 16'h0078);
      wr(A_STAT, 16'h0000);
      rd_stat(v);    check("R8 wrap flag cleared", v, 16'h0078);
    end
    cnt_down = 0;

    // R5 compare on register A; R7 unarmed write
    mode_cap_a = 0;
    wr(A_GA, 16'h0005);
    wr(A_CNT, 16'h0004);
    run(2);
    rd(A_CNT, v);  check("R11 counter 4->6", v, 16'h0006);
    wr(A_STAT, 16'h0000);
    rd_stat(v);    check("R7 unarmed write 0 keeps flag A", v, 16'h0079);
    wr(A_STAT, 16'h0001);
    rd_stat(v);    check("R8 write 1 keeps flag A", v, 16'h0079);
    wr(A_STAT, 16'h0001);
    wr(A_STAT, 16'h0000);
    rd_stat(v);    check("R8 write disarms, flag A stays", v, 16'h0079);
    wr(A_STAT, 16'h0000);
    rd_stat(v);    check("R8 read then write 0 clears A", v, 16'h0078);

    // R9 set during clear
    wr(A_CNT, 16'h0005);
    run(1);
    rd_stat(v);    check("R5 flag A set again", v, 16'h0079);
    wr(A_CNT, 16'h0005);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_STAT; bus_wdata = 0; cnt_en = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; cnt_en = 0;
    rd_stat(v);    check("R9 set beats clear", v, 16'h0079);
    wr(A_STAT, 16'h0000);
    rd_stat(v);    check("R8 clear after set event", v, 16'h0078);

    // R6 capture on B while counting
    mode_cap_b = 1;
    wr(A_CNT, 16'h1234);
    @(negedge clk); cap_pulse_b = 1; cnt_en = 1;
    @(negedge clk); cap_pulse_b = 0; cnt_en = 0;
    rd(A_GB, v);   check("R6 capture takes pre-step count", v, 16'h1234);
    rd(A_CNT, v);  check("R11 counter stepped", v, 16'h1235);
    rd_stat(v);    check("R6 flag B set", v, 16'h007A);

    // R10 capture beats bus write
    wr(A_CNT, 16'h0777);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_GB; bus_wdata = 16'hAAAA; cap_pulse_b = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; cap_pulse_b = 0;
    rd(A_GB, v);   check("R10 capture over bus write", v, 16'h0777);

    // R10 reserved bits ignore writes; flags untouched by write of ones
    wr(A_STAT, 16'h00FF);
    rd_stat(v);    check("R10 reserved bits ignore write", v, 16'h007A);
    wr(A_STAT, 16'h0000);
    rd_stat(v);    check("R8 flag B cleared", v, 16'h0078);

    // R11 counter write beats counting, no wrap
    wr(A_CNT, 16'hFFFF);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = A_CNT; bus_wdata = 16'h0010; cnt_en = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; cnt_en = 0;
    rd(A_CNT, v);  check("R11 load beats count", v, 16'h0010);
    rd_stat(v);    check("R11 no wrap on load", v, 16'h0078);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule